// File: doc/BRIEF.md
# Status Flag and Branch Condition Unit

This unit keeps the processor's 16-bit status word up to date. The arithmetic and logic unit sits outside it. Each cycle that a flag-setting operation retires, the ALU presents four things: the operation class, the operand width (byte or word), both operands, and the result with its carry, borrow or shifted-out bit. From these the unit derives the zero, sign, parity, carry and overflow flags and registers them on the next clock edge. Two control flags, direction and interrupt enable, are changed only by explicit set and clear commands. Those commands act independently of any operation in the same cycle.

A branch condition select picks one of eight jump conditions. The unit evaluates it combinationally against the registered status word, so a conditional jump sees the flags left by the preceding compare or arithmetic operation. The eight conditions cover equality tests, unsigned ordering from carry and zero, and signed ordering from sign and overflow.

Top module: `status_flag_unit`

## Requirements
- R1: After reset the status word is 0x0000. Only bits 0 (carry), 2 (parity), 6 (zero), 7 (sign), 8 (trap, which has no command and stays 0), 9 (interrupt enable), 10 (direction) and 11 (overflow) may ever be 1.
- R2: For any operation code other than 7, zero is set when the result at the selected width is zero, and sign takes the top bit at that width (bit 7 when `wide`=0, bit 15 when `wide`=1). Parity is set when the low 8 result bits hold an even number of ones. In byte mode the upper result byte is ignored.
- R3: For operation codes 0 (add), 1 (add with carry), 2 (subtract), 3 (subtract with borrow) and 4 (compare), the carry flag takes `aluCarry`, the carry-out or borrow at the selected width.
- R4: Overflow is set for codes 0 and 1 when both operands have the same sign and the result's sign differs. For codes 2, 3 and 4 it is set when the operand signs differ and the result's sign differs from operand A's sign. All signs are taken at the selected width.
- R5: Compare (code 4) updates every status flag exactly as subtract (code 2) does. It has no other effect.
- R6: Logical operations (code 5) clear carry and overflow whatever `aluCarry` is. Shifts (code 6) load carry from `aluCarry`, the last bit shifted out, and clear overflow.
- R7: Flags update on the clock edge that samples `opValid`=1. With `opValid`=0, or with operation code 7, the status flags keep their values.
- R8: `setDir`/`clrDir` write bit 10 and `setIntEn`/`clrIntEn` write bit 9 on the next edge. If set and clear arrive together, set wins. These commands do not depend on `opValid`.
- R9: `takeBranch` reflects the registered flags for the unsigned conditions: code 0 equal (ZF=1), 1 not equal (ZF=0), 2 below (CF=1), 3 not below (CF=0), 4 above (CF=0 and ZF=0), 5 not above (CF=1 or ZF=1).
- R10: `takeBranch` gives signed ordering: code 6 less (SF differs from OF) and code 7 greater-or-equal (SF equals OF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation's flags are to be captured this cycle |
| opSel | input | 3 | Operation class: 0 add, 1 add-with-carry, 2 sub, 3 sub-with-borrow, 4 compare, 5 logical, 6 shift, 7 none |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| aluResult | input | 16 | ALU result |
| aluCarry | input | 1 | Carry-out, borrow or last shifted-out bit |
| setDir | input | 1 | Set the direction flag |
| clrDir | input | 1 | Clear the direction flag |
| setIntEn | input | 1 | Set the interrupt enable flag |
| clrIntEn | input | 1 | Clear the interrupt enable flag |
| condSel | input | 3 | Branch condition code (0..7) |
| flagWord | output | 16 | Registered status word |
| takeBranch | output | 1 | Selected condition holds |

## Verification
Some properties are checked by the assertions on every cycle. The reserved bits stay clear. Idle cycles leave the word unchanged. Carry follows `aluCarry` for arithmetic and compare. Logical operations clear carry and overflow. A byte result of zero raises ZF. Setting direction takes effect on the next edge. The not-equal and signed-less conditions track the registered flags. Other properties need chosen operand pairs, so only the bench scenarios can show them. These are overflow across the 8-bit and 16-bit sign boundaries, parity, the upper-byte masking in byte mode, and the set-over-clear priority. The bench also covers how the unsigned and signed conditions split after compares of values such as 0xFFFF against 0x0001.

// File: rtl/statflag_pkg.sv
package statflag_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;

  localparam logic [15:0] FLAG_MASK = (16'h1 << CF_BIT) | (16'h1 << PF_BIT) |
                                      (16'h1 << ZF_BIT) | (16'h1 << SF_BIT) |
                                      (16'h1 << TF_BIT) | (16'h1 << IF_BIT) |
                                      (16'h1 << DF_BIT) | (16'h1 << OF_BIT);

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SBB   = 3'd3,
    OP_CMP   = 3'd4,
    OP_LOGIC = 3'd5,
    OP_SHIFT = 3'd6,
    OP_NONE  = 3'd7
  } flagOp_e;

  typedef enum logic [2:0] {
    CC_EQ = 3'd0,
    CC_NE = 3'd1,
    CC_B  = 3'd2,
    CC_NB = 3'd3,
    CC_A  = 3'd4,
    CC_NA = 3'd5,
    CC_LT = 3'd6,
    CC_GE = 3'd7
  } cond_e;

  typedef struct packed {
    logic updStatus;  // capture ZF/SF/PF/CF/OF
    logic loadCarry;  // CF from ALU, else cleared
    logic calcOvf;    // OF from sign rule, else cleared
    logic subMode;    // use subtract overflow rule
    logic dfWr;
    logic dfVal;
    logic ifWr;
    logic ifVal;
  } flagStrobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import statflag_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opSel,
  input  logic        setDir,
  input  logic        clrDir,
  input  logic        setIntEn,
  input  logic        clrIntEn,
  output flagStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (opValid) begin
      case (opSel)
        OP_ADD, OP_ADC: begin
          strobe.updStatus = 1'b1;
          strobe.loadCarry = 1'b1;
          strobe.calcOvf   = 1'b1;
        end
        OP_SUB, OP_SBB, OP_CMP: begin
          strobe.updStatus = 1'b1;
          strobe.loadCarry = 1'b1;
          strobe.calcOvf   = 1'b1;
          strobe.subMode   = 1'b1;
        end
        OP_LOGIC: strobe.updStatus = 1'b1;
        OP_SHIFT: begin
          strobe.updStatus = 1'b1;
          strobe.loadCarry = 1'b1;
        end
        default: strobe.updStatus = 1'b0;
      endcase
    end
    // Set has priority over clear when both arrive together.
    strobe.dfWr  = setDir | clrDir;
    strobe.dfVal = setDir;
    strobe.ifWr  = setIntEn | clrIntEn;
    strobe.ifVal = setIntEn;
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import statflag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  flagStrobe_t  strobe,
  input  logic         wide,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] aluResult,
  input  logic         aluCarry,
  input  logic [2:0]   condSel,
  output logic [15:0]  flagWord,
  output logic         takeBranch
);
  localparam logic [W-1:0] BYTE_MASK = W'({BYTE_W{1'b1}});
  localparam logic [W-1:0] WORD_SIGN = W'(1) << (W - 1);
  localparam logic [W-1:0] BYTE_SIGN = W'(1) << (BYTE_W - 1);

  logic [W-1:0] widthMask, signMask;
  logic zeroNow, parityNow, resSign, aSign, bSign, addOvf, subOvf, ovfNow;
  logic cfQ, pfQ, zfQ, sfQ, ofQ, dfQ, ifQ;

  assign widthMask = wide ? '1 : BYTE_MASK;
  assign signMask  = wide ? WORD_SIGN : BYTE_SIGN;

  assign zeroNow   = (aluResult & widthMask) == '0;
  assign parityNow = ~^aluResult[BYTE_W-1:0];
  assign resSign   = |(aluResult & signMask);
  assign aSign     = |(opA & signMask);
  assign bSign     = |(opB & signMask);
  assign addOvf    = (aSign == bSign) && (resSign != aSign);
  assign subOvf    = (aSign != bSign) && (resSign != aSign);
  assign ovfNow    = strobe.subMode ? subOvf : addOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {cfQ, pfQ, zfQ, sfQ, ofQ} <= '0;
    end else if (strobe.updStatus) begin
      zfQ <= zeroNow;
      sfQ <= resSign;
      pfQ <= parityNow;
      cfQ <= strobe.loadCarry & aluCarry;
      ofQ <= strobe.calcOvf & ovfNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dfQ <= 1'b0;
      ifQ <= 1'b0;
    end else begin
      if (strobe.dfWr) dfQ <= strobe.dfVal;
      if (strobe.ifWr) ifQ <= strobe.ifVal;
    end
  end

  always_comb begin
    flagWord         = '0;
    flagWord[CF_BIT] = cfQ;
    flagWord[PF_BIT] = pfQ;
    flagWord[ZF_BIT] = zfQ;
    flagWord[SF_BIT] = sfQ;
    flagWord[IF_BIT] = ifQ;
    flagWord[DF_BIT] = dfQ;
    flagWord[OF_BIT] = ofQ;
  end

  always_comb begin
    case (condSel)
      CC_EQ:   takeBranch = zfQ;
      CC_NE:   takeBranch = !zfQ;
      CC_B:    takeBranch = cfQ;
      CC_NB:   takeBranch = !cfQ;
      CC_A:    takeBranch = !cfQ && !zfQ;
      CC_NA:   takeBranch = cfQ || zfQ;
      CC_LT:   takeBranch = sfQ ^ ofQ;
      default: takeBranch = !(sfQ ^ ofQ);
    endcase
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import statflag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic              wide,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              setDir,
  input  logic              clrDir,
  input  logic              setIntEn,
  input  logic              clrIntEn,
  input  logic [2:0]        condSel,
  output logic [15:0]       flagWord,
  output logic              takeBranch
);
  flagStrobe_t strobe;

  flag_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .setDir  (setDir),
    .clrDir  (clrDir),
    .setIntEn(setIntEn),
    .clrIntEn(clrIntEn),
    .strobe  (strobe)
  );

  flag_datapath #(.W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wide      (wide),
    .opA       (opA),
    .opB       (opB),
    .aluResult (aluResult),
    .aluCarry  (aluCarry),
    .condSel   (condSel),
    .flagWord  (flagWord),
    .takeBranch(takeBranch)
  );
endmodule

// File: rtl/status_flag_unit_chk.sv
module status_flag_unit_chk
  import statflag_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opSel,
  input logic              wide,
  input logic [DATA_W-1:0] aluResult,
  input logic              aluCarry,
  input logic              setDir,
  input logic              clrDir,
  input logic              setIntEn,
  input logic              clrIntEn,
  input logic [2:0]        condSel,
  input logic [15:0]       flagWord,
  input logic              takeBranch
);
  localparam logic [DATA_W-1:0] LOW_BYTE = DATA_W'({BYTE_W{1'b1}});

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flagWord & ~FLAG_MASK) == 16'h0); // R1

  AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel != OP_NONE && !wide && (aluResult & LOW_BYTE) == '0
    |=> flagWord[ZF_BIT]); // R2

  AST_ARITH_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel <= OP_CMP |=> flagWord[CF_BIT] == $past(aluCarry)); // R3

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_LOGIC |=> !flagWord[CF_BIT] && !flagWord[OF_BIT]); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opSel == OP_NONE) && !setDir && !clrDir && !setIntEn && !clrIntEn
    |=> $stable(flagWord)); // R7

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    setDir |=> flagWord[DF_BIT]); // R8

  AST_NOT_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    condSel == CC_NE |-> takeBranch != flagWord[ZF_BIT]); // R9

  AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (!rstN)
    condSel == CC_LT |-> takeBranch == (flagWord[SF_BIT] ^ flagWord[OF_BIT])); // R10

  logic unusedWide;
  assign unusedWide = wide;
endmodule

bind status_flag_unit status_flag_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opSel     (opSel),
  .wide      (wide),
  .aluResult (aluResult),
  .aluCarry  (aluCarry),
  .setDir    (setDir),
  .clrDir    (clrDir),
  .setIntEn  (setIntEn),
  .clrIntEn  (clrIntEn),
  .condSel   (condSel),
  .flagWord  (flagWord),
  .takeBranch(takeBranch)
);

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opSel = 3'd7;
  logic wide = 1'b1;
  logic [15:0] opA = '0, opB = '0, aluResult = '0;
  logic aluCarry = 1'b0;
  logic setDir = 1'b0, clrDir = 1'b0, setIntEn = 1'b0, clrIntEn = 1'b0;
  logic [2:0] condSel = 3'd0;
  logic [15:0] flagWord;
  logic takeBranch;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] mdl = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .wide(wide),
    .opA(opA), .opB(opB), .aluResult(aluResult), .aluCarry(aluCarry),
    .setDir(setDir), .clrDir(clrDir), .setIntEn(setIntEn), .clrIntEn(clrIntEn),
    .condSel(condSel), .flagWord(flagWord), .takeBranch(takeBranch)
  );

  task automatic checkVal(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, compute its expected flags, check after the edge.
  task automatic runOp(input string req, input logic [2:0] op, input logic w,
                       input logic [15:0] a, input logic [15:0] b);
    logic [15:0] msk = w ? 16'hFFFF : 16'h00FF;
    int top = w ? 15 : 7;
    logic [16:0] am = {1'b0, a & msk};
    logic [16:0] bm = {1'b0, b & msk};
    logic cin = mdl[0];
    logic [16:0] full;
    logic [15:0] r;
    logic c;
    logic [15:0] e = mdl;
    case (op)
      3'd0: full = am + bm;
      3'd1: full = am + bm + 17'(cin);
      3'd3: full = am - bm - 17'(cin);
      3'd2, 3'd4: full = am - bm;
      3'd5: full = {1'b0, (a | b) & msk};
      3'd6: full = {1'b0, (a & msk) << 1};
      default: full = {1'b0, a};
    endcase
    r = full[15:0] & msk;
    case (op)
      3'd0, 3'd1: c = w ? full[16] : full[8];
      3'd2, 3'd4: c = am < bm;
      3'd3: c = am < (bm + 17'(cin));
      3'd6: c = a[top];
      default: c = 1'b1;  // must be ignored
    endcase
    if (op != 3'd7) begin
      e[6] = (r == 16'h0);
      e[7] = r[top];
      e[2] = ~^r[7:0];
      e[0] = (op <= 3'd4 || op == 3'd6) ? c : 1'b0;
      if (op <= 3'd1)      e[11] = (a[top] == b[top]) && (r[top] != a[top]);
      else if (op <= 3'd4) e[11] = (a[top] != b[top]) && (r[top] != a[top]);
      else                 e[11] = 1'b0;
    end
    @(negedge clk);
    opValid = 1'b1; opSel = op; wide = w; opA = a; opB = b; aluCarry = c;
    aluResult = w ? r : (r | 16'h5A00);  // upper byte noise in byte mode
    @(posedge clk); #1;
    opValid = 1'b0;
    mdl = e;
    checkVal(req, flagWord, mdl);
  endtask

  task automatic runCmd(input string req, input logic sd, input logic cd,
                        input logic si, input logic ci);
    @(negedge clk);
    setDir = sd; clrDir = cd; setIntEn = si; clrIntEn = ci;
    @(posedge clk); #1;
    setDir = 0; clrDir = 0; setIntEn = 0; clrIntEn = 0;
    if (sd) mdl[10] = 1'b1; else if (cd) mdl[10] = 1'b0;
    if (si) mdl[9] = 1'b1; else if (ci) mdl[9] = 1'b0;
    checkVal(req, flagWord, mdl);
  endtask

  task automatic checkConds(input string tag);
    for (int cc = 0; cc < 8; cc++) begin
      logic ex;
      condSel = 3'(cc);
      #1;
      case (cc)
        0: ex = mdl[6];
        1: ex = !mdl[6];
        2: ex = mdl[0];
        3: ex = !mdl[0];
        4: ex = !mdl[0] && !mdl[6];
        5: ex = mdl[0] || mdl[6];
        6: ex = mdl[7] ^ mdl[11];
        default: ex = !(mdl[7] ^ mdl[11]);
      endcase
      checkVal($sformatf("%s cond=%0d %s", (cc < 6) ? "R9" : "R10", cc, tag),
               {15'h0, takeBranch}, {15'h0, ex});
    end
  endtask

  task automatic testIdle();
    @(negedge clk);
    opValid = 1'b0; opSel = 3'd0; aluResult = 16'h0000; aluCarry = 1'b1;
    @(posedge clk); #1;
    checkVal("R7 opValid low holds", flagWord, mdl);
    @(negedge clk);
    opValid = 1'b1; opSel = 3'd7; aluResult = 16'h0000; aluCarry = 1'b1;
    @(posedge clk); #1;
    opValid = 1'b0;
    checkVal("R7 op 7 holds", flagWord, mdl);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    checkVal("R1 reset word", flagWord, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkVal("R1 after release", flagWord, 16'h0000);

    runOp("R4 R2 word add overflow", 3'd0, 1'b1, 16'h7FFF, 16'h0001);
    checkConds("after 7FFF+1");
    runOp("R2 R3 byte add wraps to zero", 3'd0, 1'b0, 16'h12FF, 16'h3401);
    runOp("R4 byte sub overflow", 3'd2, 1'b0, 16'h0080, 16'h0001);
    runOp("R5 cmp below", 3'd4, 1'b1, 16'h0003, 16'h0005);
    checkConds("after cmp 3,5");
    runOp("R5 cmp equal", 3'd4, 1'b1, 16'h1234, 16'h1234);
    checkConds("after cmp equal");
    runOp("R5 R10 cmp FFFF,0001", 3'd4, 1'b1, 16'hFFFF, 16'h0001);
    checkConds("after cmp FFFF,1");
    runOp("R10 signed overflow cmp", 3'd4, 1'b1, 16'h8000, 16'h0001);
    checkConds("after cmp 8000,1");
    runOp("R3 add sets carry", 3'd0, 1'b1, 16'hFFFF, 16'h0002);
    runOp("R3 add with carry", 3'd1, 1'b1, 16'h0001, 16'h0001);
    runOp("R3 sub sets borrow", 3'd2, 1'b0, 16'h0001, 16'h0002);
    runOp("R3 sub with borrow", 3'd3, 1'b0, 16'h0010, 16'h0001);
    runOp("R4 add with carry overflow", 3'd1, 1'b0, 16'h0040, 16'h0040);
    runOp("R6 logical clears CF OF", 3'd5, 1'b1, 16'h0F0F, 16'h7000);
    runOp("R6 shift carry out", 3'd6, 1'b1, 16'h8000, 16'h0000);
    runOp("R6 byte shift carry out", 3'd6, 1'b0, 16'h00C1, 16'h0000);
    testIdle();
    runCmd("R8 set direction", 1, 0, 0, 0);
    runCmd("R8 set interrupt", 0, 0, 1, 0);
    runCmd("R8 clear direction", 0, 1, 0, 0);
    runCmd("R8 set wins over clear", 1, 1, 0, 1);
    runCmd("R8 clear interrupt", 0, 0, 0, 1);
    runCmd("R8 set wins on interrupt", 0, 0, 1, 1);
    runOp("R8 op keeps control flags", 3'd2, 1'b1, 16'h0000, 16'h0001);
    checkConds("after sub 0,1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule